// File: doc/BRIEF.md
# Quirk-Configurable Register ALU

This block carries out the register-to-register arithmetic and logic group of a small 8-bit interpreter-style processor. It holds sixteen 8-bit registers. When started with a sub-operation code and two register indices X and Y, it reads both operands, computes the result and writes it back to X. Depending on the operation, it then also writes the last register, which serves as the flag register. Execution takes a single clock edge. A done pulse follows one cycle after the start strobe. An undefined code raises an illegal-operation pulse instead of changing anything.

Two static configuration inputs select between two historical behaviours. One makes the three bitwise operations clear the flag register. The other makes both shifts take their operand from Y instead of X. A host port writes registers and reads them back with one cycle of latency. This lets the surrounding core, or a bench, load operands and observe results.

Top module: `quirk_alu`

## Requirements
- R1: While rst_n is low, every register, op_done, op_illegal and host_rdata are cleared to zero.
- R2: Code 0 (move) writes Y's value into X and leaves register 15 untouched, whatever the configuration.
- R3: Codes 1, 2 and 3 write X|Y, X&Y and X^Y into X. If cfg_logic_clr_flag is 1, register 15 then becomes 0. If it is 0, register 15 is untouched.
- R4: Code 4 writes (X+Y) mod 256 into X and sets register 15 to 1 on a carry out of bit 7, else to 0.
- R5: Code 5 writes (X-Y) mod 256 into X. Code 7 writes (Y-X) mod 256 into X. For both, register 15 becomes 1 when the minuend is not smaller than the subtrahend (no borrow) and 0 otherwise.
- R6: Code 6 writes src>>1 into X and puts src bit 0 into register 15. Code E writes (src<<1) mod 256 into X and puts src bit 7 into register 15. src is Y when cfg_shift_from_y is 1 and X otherwise.
- R7: When X is register 15 and the operation writes the flag, register 15 ends up holding the flag, not the result.
- R8: Codes 8 to D and F change no register. For them, op_illegal is high for exactly the one cycle after the start.
- R9: op_done is high in the cycle after every cycle with op_start high, and low after every cycle with op_start low.
- R10: A host write updates its register at the next edge. host_rdata shows the register chosen by host_raddr one cycle after the address. A host write presented together with op_start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_logic_clr_flag | input | 1 | Bitwise operations clear register 15 |
| cfg_shift_from_y | input | 1 | Shifts read their operand from Y |
| op_start | input | 1 | Execute the operation presented this cycle |
| op_code | input | 4 | Sub-operation code |
| op_x | input | 4 | Index of X (operand and destination) |
| op_y | input | 4 | Index of Y (operand) |
| op_done | output | 1 | Operation completed, one cycle pulse |
| op_illegal | output | 1 | Undefined code seen, one cycle pulse |
| host_we | input | 1 | Host register write enable |
| host_waddr | input | 4 | Host write index |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 4 | Host read index |
| host_rdata | output | 8 | Registered host read data |

## Verification
A wrong internal value in this block becomes visible at the ports two cycles after the operation starts. One edge writes the register file, and the registered host read needs one more edge. So every vector reads both X and register 15 straight after the operation. A fault in the flag-select logic, such as the wrong shift source or a flag written before the result, shows up only in register 15. Those faults are caught by reading it after every operation that starts from a known sentinel value. A bad done or illegal pulse shows up on the very next cycle.

// File: rtl/quirk_alu_pkg.sv
package quirk_alu_pkg;
    localparam int DATA_W = 8;
    localparam int REG_N  = 16;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_MOV = 4'h0,
        OP_OR  = 4'h1,
        OP_AND = 4'h2,
        OP_XOR = 4'h3,
        OP_ADD = 4'h4,
        OP_SUB = 4'h5,
        OP_SHR = 4'h6,
        OP_RSB = 4'h7,
        OP_SHL = 4'hE
    } alu_op_e;
endpackage

// File: rtl/quirk_alu_core.sv
module quirk_alu_core
    import quirk_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [CODE_W-1:0] op_i,
    input  logic [DW-1:0]     vx_i,
    input  logic [DW-1:0]     vy_i,
    input  logic              cfg_clr_i,
    input  logic              cfg_shy_i,
    output logic [DW-1:0]     res_o,
    output logic              res_we_o,
    output logic [DW-1:0]     flag_o,
    output logic              flag_we_o,
    output logic              illegal_o
);
    logic [DW:0]   sum_w;
    logic [DW:0]   dxy_w;
    logic [DW:0]   dyx_w;
    logic [DW-1:0] src_w;

    assign sum_w = {1'b0, vx_i} + {1'b0, vy_i};
    assign dxy_w = {1'b0, vx_i} - {1'b0, vy_i};
    assign dyx_w = {1'b0, vy_i} - {1'b0, vx_i};
    assign src_w = cfg_shy_i ? vy_i : vx_i;

    always_comb begin
        res_o     = vx_i;
        res_we_o  = 1'b0;
        flag_o    = '0;
        flag_we_o = 1'b0;
        illegal_o = 1'b0;
        case (alu_op_e'(op_i))
            OP_MOV: begin
                res_o    = vy_i;
                res_we_o = 1'b1;
            end
            OP_OR: begin
                res_o     = vx_i | vy_i;
                res_we_o  = 1'b1;
                flag_we_o = cfg_clr_i;
            end
            OP_AND: begin
                res_o     = vx_i & vy_i;
                res_we_o  = 1'b1;
                flag_we_o = cfg_clr_i;
            end
            OP_XOR: begin
                res_o     = vx_i ^ vy_i;
                res_we_o  = 1'b1;
                flag_we_o = cfg_clr_i;
            end
            OP_ADD: begin
                res_o     = sum_w[DW-1:0];
                res_we_o  = 1'b1;
                flag_o    = {{(DW-1){1'b0}}, sum_w[DW]};
                flag_we_o = 1'b1;
            end
            OP_SUB: begin
                res_o     = dxy_w[DW-1:0];
                res_we_o  = 1'b1;
                flag_o    = {{(DW-1){1'b0}}, ~dxy_w[DW]};
                flag_we_o = 1'b1;
            end
            OP_RSB: begin
                res_o     = dyx_w[DW-1:0];
                res_we_o  = 1'b1;
                flag_o    = {{(DW-1){1'b0}}, ~dyx_w[DW]};
                flag_we_o = 1'b1;
            end
            OP_SHR: begin
                res_o     = src_w >> 1;
                res_we_o  = 1'b1;
                flag_o    = {{(DW-1){1'b0}}, src_w[0]};
                flag_we_o = 1'b1;
            end
            OP_SHL: begin
                res_o     = src_w << 1;
                res_we_o  = 1'b1;
                flag_o    = {{(DW-1){1'b0}}, src_w[DW-1]};
                flag_we_o = 1'b1;
            end
            default: illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/quirk_alu_regs.sv
module quirk_alu_regs #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we_i,
    input  logic [AW-1:0]            host_waddr_i,
    input  logic [DW-1:0]            host_wdata_i,
    input  logic [AW-1:0]            host_raddr_i,
    output logic [DW-1:0]            host_rdata_o,
    input  logic                     res_we_i,
    input  logic [AW-1:0]            res_addr_i,
    input  logic [DW-1:0]            res_data_i,
    input  logic                     flag_we_i,
    input  logic [DW-1:0]            flag_data_i,
    output logic [NREG-1:0][DW-1:0]  file_o
);
    localparam logic [AW-1:0] FLAG_IDX = AW'(NREG - 1);

    logic [NREG-1:0][DW-1:0] file_d, file_q;
    logic [DW-1:0]           rdata_d, rdata_q;

    always_comb begin
        file_d = file_q;
        if (host_we_i) file_d[host_waddr_i] = host_wdata_i;
        if (res_we_i)  file_d[res_addr_i]   = res_data_i;
        if (flag_we_i) file_d[FLAG_IDX]     = flag_data_i;
        rdata_d = file_q[host_raddr_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            file_q  <= '0;
            rdata_q <= '0;
        end else begin
            file_q  <= file_d;
            rdata_q <= rdata_d;
        end
    end

    assign file_o       = file_q;
    assign host_rdata_o = rdata_q;
endmodule

// File: rtl/quirk_alu.sv
module quirk_alu
    import quirk_alu_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NREG = REG_N,
    localparam int AW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_logic_clr_flag,
    input  logic              cfg_shift_from_y,
    input  logic              op_start,
    input  logic [CODE_W-1:0] op_code,
    input  logic [AW-1:0]     op_x,
    input  logic [AW-1:0]     op_y,
    output logic              op_done,
    output logic              op_illegal,
    input  logic              host_we,
    input  logic [AW-1:0]     host_waddr,
    input  logic [DW-1:0]     host_wdata,
    input  logic [AW-1:0]     host_raddr,
    output logic [DW-1:0]     host_rdata
);
    typedef struct packed {
        logic done;
        logic illegal;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NREG-1:0][DW-1:0] regs_w;
    logic [DW-1:0]           res_w, flag_w;
    logic                    res_we_w, flag_we_w, illegal_w;

    quirk_alu_core #(.DW(DW)) i_core (
        .op_i      (op_code),
        .vx_i      (regs_w[op_x]),
        .vy_i      (regs_w[op_y]),
        .cfg_clr_i (cfg_logic_clr_flag),
        .cfg_shy_i (cfg_shift_from_y),
        .res_o     (res_w),
        .res_we_o  (res_we_w),
        .flag_o    (flag_w),
        .flag_we_o (flag_we_w),
        .illegal_o (illegal_w)
    );

    quirk_alu_regs #(.DW(DW), .NREG(NREG)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we_i    (host_we & ~op_start),
        .host_waddr_i (host_waddr),
        .host_wdata_i (host_wdata),
        .host_raddr_i (host_raddr),
        .host_rdata_o (host_rdata),
        .res_we_i     (op_start & res_we_w),
        .res_addr_i   (op_x),
        .res_data_i   (res_w),
        .flag_we_i    (op_start & flag_we_w),
        .flag_data_i  (flag_w),
        .file_o       (regs_w)
    );

    always_comb begin
        ctl_d.done    = op_start;
        ctl_d.illegal = op_start & illegal_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign op_done    = ctl_q.done;
    assign op_illegal = ctl_q.illegal;
endmodule

// File: rtl/quirk_alu_chk.sv
module quirk_alu_chk #(
    parameter int DW   = 8,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_logic_clr_flag,
    input logic                    op_start,
    input logic [3:0]              op_code,
    input logic [AW-1:0]           op_x,
    input logic                    op_done,
    input logic                    op_illegal,
    input logic [NREG-1:0][DW-1:0] regs_w
);
    localparam logic [AW-1:0] FLAG_IDX = AW'(NREG - 1);

    a_r9_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> op_done);

    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !op_start |=> !op_done);

    a_r8_illegal_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> op_done);

    a_r8_illegal_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && (op_code inside {[4'h8:4'hD], 4'hF})) |=> (op_illegal && $stable(regs_w)));

    a_r3_bitwise_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && cfg_logic_clr_flag && (op_code inside {4'h1, 4'h2, 4'h3}))
            |=> (regs_w[FLAG_IDX] == '0));

    a_r2_move_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_code == 4'h0 && op_x != FLAG_IDX) |=> $stable(regs_w[FLAG_IDX]));
endmodule

bind quirk_alu quirk_alu_chk #(.DW(DW), .NREG(NREG)) i_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .cfg_logic_clr_flag (cfg_logic_clr_flag),
    .op_start           (op_start),
    .op_code            (op_code),
    .op_x               (op_x),
    .op_done            (op_done),
    .op_illegal         (op_illegal),
    .regs_w             (regs_w)
);

// File: tb/test_quirk_alu.sv
module test_quirk_alu;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_logic_clr_flag, cfg_shift_from_y;
    logic       op_start;
    logic [3:0] op_code, op_x, op_y;
    logic       op_done, op_illegal;
    logic       host_we;
    logic [3:0] host_waddr, host_raddr;
    logic [7:0] host_wdata, host_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    quirk_alu i_quirk_alu (
        .clk(clk), .rst_n(rst_n),
        .cfg_logic_clr_flag(cfg_logic_clr_flag), .cfg_shift_from_y(cfg_shift_from_y),
        .op_start(op_start), .op_code(op_code), .op_x(op_x), .op_y(op_y),
        .op_done(op_done), .op_illegal(op_illegal),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    // {code, vx, vy, clr, shy, exp_x, exp_f}; X=1, Y=2, flag preset A5
    localparam int NV = 16;
    localparam logic [37:0] VEC [NV] = '{
        {4'h0, 8'h11, 8'h3C, 1'b1, 1'b0, 8'h3C, 8'hA5},
        {4'h1, 8'h0F, 8'hF0, 1'b1, 1'b0, 8'hFF, 8'h00},
        {4'h1, 8'h0F, 8'hF0, 1'b0, 1'b0, 8'hFF, 8'hA5},
        {4'h2, 8'hCC, 8'hAA, 1'b1, 1'b0, 8'h88, 8'h00},
        {4'h3, 8'hCC, 8'hAA, 1'b0, 1'b0, 8'h66, 8'hA5},
        {4'h4, 8'hF0, 8'h20, 1'b0, 1'b0, 8'h10, 8'h01},
        {4'h4, 8'h10, 8'h20, 1'b0, 1'b0, 8'h30, 8'h00},
        {4'h5, 8'h50, 8'h30, 1'b0, 1'b0, 8'h20, 8'h01},
        {4'h5, 8'h30, 8'h50, 1'b0, 1'b0, 8'hE0, 8'h00},
        {4'h5, 8'h40, 8'h40, 1'b0, 1'b0, 8'h00, 8'h01},
        {4'h7, 8'h10, 8'h30, 1'b0, 1'b0, 8'h20, 8'h01},
        {4'h7, 8'h30, 8'h10, 1'b0, 1'b0, 8'hE0, 8'h00},
        {4'h6, 8'h81, 8'h02, 1'b0, 1'b0, 8'h40, 8'h01},
        {4'h6, 8'h81, 8'h02, 1'b0, 1'b1, 8'h01, 8'h00},
        {4'hE, 8'h81, 8'h02, 1'b0, 1'b0, 8'h02, 8'h01},
        {4'hE, 8'h81, 8'h40, 1'b0, 1'b1, 8'h80, 8'h00}
    };

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'h0:               return "R2";
            4'h1, 4'h2, 4'h3:   return "R3";
            4'h4:               return "R4";
            4'h5, 4'h7:         return "R5";
            default:            return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        host_raddr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic run(input logic [3:0] c, input logic [3:0] x, input logic [3:0] y,
                       output logic done_s, output logic ill_s);
        op_start = 1'b1; op_code = c; op_x = x; op_y = y;
        @(negedge clk);
        op_start = 1'b0;
        done_s = op_done;
        ill_s  = op_illegal;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic d_s, i_s;
        rst_n = 1'b0; op_start = 1'b0; op_code = '0; op_x = '0; op_y = '0;
        host_we = 1'b0; host_waddr = '0; host_wdata = '0; host_raddr = '0;
        cfg_logic_clr_flag = 1'b0; cfg_shift_from_y = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1", {7'b0, op_done}, 8'h00);
        chk("R1", {7'b0, op_illegal}, 8'h00);
        chk("R1", host_rdata, 8'h00);
        rst_n = 1'b1;
        for (int r = 0; r < 16; r++) begin
            rd(4'(r), got);
            chk("R1", got, 8'h00);
        end

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            cfg_logic_clr_flag = v[17];
            cfg_shift_from_y   = v[16];
            wr(4'hF, 8'hA5);
            wr(4'h1, v[33:26]);
            wr(4'h2, v[25:18]);
            run(v[37:34], 4'h1, 4'h2, d_s, i_s);
            chk("R9", {7'b0, d_s}, 8'h01);
            chk("R8", {7'b0, i_s}, 8'h00);
            rd(4'h1, got);
            chk(tag_of(v[37:34]), got, v[15:8]);
            rd(4'hF, got);
            chk(tag_of(v[37:34]), got, v[7:0]);
        end
        // R9: done falls after a single start
        chk("R9", {7'b0, op_done}, 8'h00);

        // R7: X is register 15, add with carry -> flag wins
        cfg_logic_clr_flag = 1'b0; cfg_shift_from_y = 1'b0;
        wr(4'hF, 8'hF0); wr(4'h2, 8'h20);
        run(4'h4, 4'hF, 4'h2, d_s, i_s);
        rd(4'hF, got);
        chk("R7", got, 8'h01);
        // R7: X is register 15, add without carry -> flag 0 wins over 0x30
        wr(4'hF, 8'h10);
        run(4'h4, 4'hF, 4'h2, d_s, i_s);
        rd(4'hF, got);
        chk("R7", got, 8'h00);
        // R7: bitwise with clear off and X=15 keeps the result
        wr(4'hF, 8'h0F); wr(4'h2, 8'hF0);
        run(4'h1, 4'hF, 4'h2, d_s, i_s);
        rd(4'hF, got);
        chk("R7", got, 8'hFF);

        // R8: undefined codes change nothing, illegal pulses once
        wr(4'h1, 8'h77); wr(4'h2, 8'h11); wr(4'hF, 8'hA5);
        run(4'h8, 4'h1, 4'h2, d_s, i_s);
        chk("R8", {7'b0, i_s}, 8'h01);
        chk("R9", {7'b0, d_s}, 8'h01);
        @(negedge clk);
        chk("R8", {7'b0, op_illegal}, 8'h00);
        run(4'hF, 4'h1, 4'h2, d_s, i_s);
        chk("R8", {7'b0, i_s}, 8'h01);
        rd(4'h1, got);
        chk("R8", got, 8'h77);
        rd(4'hF, got);
        chk("R8", got, 8'hA5);

        // R10: host write during op_start ignored
        wr(4'h3, 8'h5A);
        host_we = 1'b1; host_waddr = 4'h3; host_wdata = 8'h99;
        run(4'h0, 4'h1, 4'h2, d_s, i_s);
        host_we = 1'b0;
        rd(4'h3, got);
        chk("R10", got, 8'h5A);
        rd(4'h1, got);
        chk("R2", got, 8'h11);

        // R1: reset mid-run clears registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'h3, got);
        chk("R1", got, 8'h00);
        rd(4'hF, got);
        chk("R1", got, 8'h00);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule